// File: doc/BRIEF.md
# Relative Pointer Packet Encoder

This block gathers relative pointer motion and three-button state changes and turns them into a fixed five-byte report when a sync strobe arrives. The reports are written into a byte FIFO whose head is exposed with a valid/ready handshake. A downstream serial receive channel drains it. Horizontal motion keeps its sign. Vertical motion is stored negated. Each motion byte is limited to ±127. Whatever does not fit stays in the accumulator and goes out in a later report, so no motion is lost.

A report is built only when there is something to say: non-zero motion on either axis, or a button event since the last report. The first byte carries the button levels inverted over a fixed pattern. The next two are the clamped motion values. The last two are always zero.

Top module: `mouse_pkt_enc`

## Requirements
- R1: Button events use `btn_evt_i` bit 2 for left, bit 1 for middle and bit 0 for right. For each strobed bit, `btn_down_i` gives the new level. Any event sets a pending-change flag.
- R2: `dx_i` is added to the horizontal accumulator as given. `dy_i` is subtracted from the vertical accumulator.
- R3: A sync seen while both accumulators are zero and no change is pending produces no bytes.
- R4: The first byte of a report is 0x87 XOR {5'b0, left, middle, right}, so a held button reads as 0. Sending a report clears the pending-change flag unless a button event arrives in that same cycle.
- R5: Bytes 2 and 3 are the horizontal and then the vertical accumulator, each clamped to −127..+127 and encoded as 8-bit two's complement.
- R6: The clamped amount is subtracted from each accumulator when the report is taken. The remainder is sent in later reports.
- R7: Bytes 4 and 5 of every report are 0x00.
- R8: Report bytes enter the FIFO one per cycle, in order, starting the cycle after the sync. A byte offered while the FIFO holds FIFO_DEPTH entries is dropped. The FIFO presents its bytes in arrival order.
- R9: The accumulators are ACC_W-bit signed values that saturate at their limits instead of wrapping.
- R10: A sync that arrives while a report is still being written is ignored. Motion or button events in the cycle of an accepted sync belong to the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| move_valid_i | input | 1 | Qualifies dx_i and dy_i for one cycle |
| dx_i | input | DELTA_W | Signed horizontal delta |
| dy_i | input | DELTA_W | Signed vertical delta |
| btn_evt_i | input | 3 | Per-button event strobe: [2] left, [1] middle, [0] right |
| btn_down_i | input | 3 | New level for each strobed button (1 = pressed) |
| sync_i | input | 1 | Request a report |
| out_valid_o | output | 1 | FIFO head byte is valid |
| out_data_o | output | 8 | FIFO head byte |
| out_ready_i | input | 1 | Consumer takes the head byte |

## Verification
The assertions assume that `out_ready_i` is only meaningful while `out_valid_o` is high. They also assume that sync, motion and button strobes are single-cycle pulses sampled on the rising edge. The bench drives every input just after a falling edge and releases it one cycle later. It pops bytes only once a report has finished writing. Because of this, its model can predict FIFO occupancy and drops without knowing the internal state.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int          FRAME_LEN = 5;
  localparam logic [7:0]  HDR_BASE  = 8'h87;
  localparam int          BTN_N     = 3;
endpackage

// File: rtl/mpe_accum.sv
module mpe_accum #(
  parameter int ACC_W = 16,
  parameter int IN_W  = 12,
  parameter bit NEG   = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    add_i,
  input  logic [IN_W-1:0]         delta_i,
  input  logic                    take_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic [7:0]              part_o
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] HI   = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] LO   = -HI - 1;
  localparam logic signed [SW-1:0] P127 = 127;
  localparam logic signed [SW-1:0] N127 = -P127;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [SW-1:0]    a_x, d_raw, d_x, t_x, sum, nxt;

  assign a_x   = $signed({{2{acc_q[ACC_W-1]}}, acc_q});
  assign d_raw = $signed({{(SW-IN_W){delta_i[IN_W-1]}}, delta_i});

  generate
    if (NEG) begin : g_neg
      assign d_x = -d_raw;
    end else begin : g_pos
      assign d_x = d_raw;
    end
  endgenerate

  always_comb begin
    if (a_x > P127)      t_x = P127;
    else if (a_x < N127) t_x = N127;
    else                 t_x = a_x;
  end

  always_comb begin
    sum = a_x + (add_i ? d_x : '0) - (take_i ? t_x : '0);
    if (sum > HI)      nxt = HI;
    else if (sum < LO) nxt = LO;
    else               nxt = sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= nxt[ACC_W-1:0];
  end

  assign acc_o  = acc_q;
  assign part_o = t_x[7:0];
endmodule

// File: rtl/mpe_btn.sv
module mpe_btn
  import mpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BTN_N-1:0] evt_i,
  input  logic [BTN_N-1:0] down_i,
  input  logic             take_i,
  output logic [BTN_N-1:0] state_o,
  output logic             chg_o
);
  logic [BTN_N-1:0] state_q;
  logic             chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      for (int i = 0; i < BTN_N; i++)
        if (evt_i[i]) state_q[i] <= down_i[i];
      if (|evt_i)      chg_q <= 1'b1;
      else if (take_i) chg_q <= 1'b0;
    end
  end

  assign state_o = state_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/mpe_framer.sv
module mpe_framer
  import mpe_pkg::*;
#(
  parameter int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             report_i,
  input  logic [7:0]       hdr_i,
  input  logic [7:0]       bx_i,
  input  logic [7:0]       by_i,
  output logic             take_o,
  output logic             push_o,
  output logic [7:0]       push_data_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hdr_q, bx_q, by_q;

  assign take_o = sync_i && !busy_q && report_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      hdr_q  <= '0;
      bx_q   <= '0;
      by_q   <= '0;
    end else if (take_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      hdr_q  <= hdr_i;
      bx_q   <= bx_i;
      by_q   <= by_i;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (idx_q)
      IDX_W'(0): push_data_o = hdr_q;
      IDX_W'(1): push_data_o = bx_q;
      IDX_W'(2): push_data_o = by_q;
      default:   push_data_o = 8'h00;
    endcase
  end

  assign push_o = busy_q;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/mpe_fifo.sv
module mpe_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  input  logic         ready_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [AW:0]   cnt_q;
  logic          wr_en, rd_en;

  assign wr_en = push_i && (cnt_q != FULL);
  assign rd_en = ready_i && valid_o;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (rd_en) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int DELTA_W    = 12,
  parameter int ACC_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               move_valid_i,
  input  logic [DELTA_W-1:0] dx_i,
  input  logic [DELTA_W-1:0] dy_i,
  input  logic [2:0]         btn_evt_i,
  input  logic [2:0]         btn_down_i,
  input  logic               sync_i,
  output logic               out_valid_o,
  output logic [7:0]         out_data_o,
  input  logic               out_ready_i
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic signed [ACC_W-1:0] acc_q [2];
  logic [7:0]              part [2];
  logic [DELTA_W-1:0]      delta [2];
  logic [BTN_N-1:0]        btn_state;
  logic                    chg, take, report;
  logic                    fr_push, fr_busy;
  logic [7:0]              fr_data;
  logic [IDX_W-1:0]        fr_idx;

  assign delta[0] = dx_i;
  assign delta[1] = dy_i;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_axis
      mpe_accum #(.ACC_W(ACC_W), .IN_W(DELTA_W), .NEG(g == 1)) u_acc (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .add_i   (move_valid_i),
        .delta_i (delta[g]),
        .take_i  (take),
        .acc_o   (acc_q[g]),
        .part_o  (part[g])
      );
    end
  endgenerate

  mpe_btn u_btn (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (btn_evt_i),
    .down_i  (btn_down_i),
    .take_i  (take),
    .state_o (btn_state),
    .chg_o   (chg)
  );

  assign report = chg || (acc_q[0] != '0) || (acc_q[1] != '0);

  mpe_framer #(.IDX_W(IDX_W)) u_frm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .report_i    (report),
    .hdr_i       (HDR_BASE ^ {5'b0, btn_state}),
    .bx_i        (part[0]),
    .by_i        (part[1]),
    .take_o      (take),
    .push_o      (fr_push),
    .push_data_o (fr_data),
    .busy_o      (fr_busy),
    .idx_o       (fr_idx)
  );

  mpe_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (fr_push),
    .data_i  (fr_data),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .ready_i (out_ready_i)
  );
endmodule

// File: rtl/mpe_checker.sv
module mpe_checker #(
  parameter int ACC_W = 16,
  parameter int IDX_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sync_i,
  input logic [2:0]              btn_evt_i,
  input logic                    busy,
  input logic                    push,
  input logic [IDX_W-1:0]        idx,
  input logic [7:0]              push_data,
  input logic signed [ACC_W-1:0] acc_x,
  input logic signed [ACC_W-1:0] acc_y,
  input logic                    chg,
  input logic                    out_valid_o,
  input logic [7:0]              out_data_o,
  input logic                    out_ready_i
);
  p_quiet_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i && !busy && !chg && acc_x == '0 && acc_y == '0 |=> !busy);

  p_hdr_form_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && idx == IDX_W'(0) |-> push_data[7:3] == 5'b10000);

  p_flag_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i && !busy && chg && btn_evt_i == 3'b000 |=> !chg);

  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && (idx == IDX_W'(1) || idx == IDX_W'(2)) |-> push_data != 8'h80);

  p_tail_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && idx >= IDX_W'(3) |-> push_data == 8'h00);

  p_head_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_busy_run_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && idx != IDX_W'(4) |=> busy && idx == $past(idx) + 1'b1);
endmodule

bind mouse_pkt_enc mpe_checker #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_i      (sync_i),
  .btn_evt_i   (btn_evt_i),
  .busy        (fr_busy),
  .push        (fr_push),
  .idx         (fr_idx),
  .push_data   (fr_data),
  .acc_x       (acc_q[0]),
  .acc_y       (acc_q[1]),
  .chg         (chg),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .out_ready_i (out_ready_i)
);

// File: tb/mouse_pkt_enc_tb_top.sv
`timescale 1ns/1ps
module mouse_pkt_enc_tb_top;
  localparam int DW = 12;
  localparam int DEPTH = 8;
  localparam int AMAX = 32767;
  localparam int AMIN = -32768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mv = 1'b0;
  logic [DW-1:0] dx = '0, dy = '0;
  logic [2:0]    evt = '0, dn = '0;
  logic          sy = 1'b0;
  logic          ov;
  logic [7:0]    od;
  logic          rdy = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;
  int ax = 0, ay = 0, busy_m = 0;
  bit chg_m = 0;
  logic [2:0] btn_m = '0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  mouse_pkt_enc #(.DELTA_W(DW), .ACC_W(16), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .move_valid_i(mv), .dx_i(dx), .dy_i(dy),
    .btn_evt_i(evt), .btn_down_i(dn), .sync_i(sy),
    .out_valid_o(ov), .out_data_o(od), .out_ready_i(rdy));

  function automatic int sat(int v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  function automatic int clp(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qpush(int b);
    if (exp_q.size() < DEPTH) exp_q.push_back(b & 8'hff);  // R8 drop when full
  endtask

  // One cycle of stimulus plus the reference model for that edge.
  task automatic drive(int ddx, int ddy, bit m, logic [2:0] e, logic [2:0] d, bit s);
    int cx, cy;
    bit acc;
    mv = m; dx = DW'(ddx); dy = DW'(ddy); evt = e; dn = d; sy = s;
    acc = s && busy_m == 0 && (chg_m || ax != 0 || ay != 0);
    if (acc) begin
      cx = clp(ax); cy = clp(ay);
      qpush(8'h87 ^ {5'b0, btn_m});
      qpush(cx); qpush(cy); qpush(0); qpush(0);
      ax -= cx; ay -= cy; chg_m = 0;
    end
    if (m) begin
      ax = sat(ax + ddx);
      ay = sat(ay - ddy);
    end
    for (int i = 0; i < 3; i++) if (e[i]) btn_m[i] = d[i];
    if (|e) chg_m = 1;
    busy_m = acc ? 5 : (busy_m > 0 ? busy_m - 1 : 0);
    @(negedge clk);
    mv = 0; evt = '0; dn = '0; sy = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 3'b0, 3'b0, 0);
  endtask

  task automatic move(int a, int b);
    drive(a, b, 1, 3'b0, 3'b0, 0);
  endtask

  task automatic sync1();
    drive(0, 0, 0, 3'b0, 3'b0, 1);
  endtask

  task automatic drain(string tag);
    int e;
    idle(6);
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(ov == 1'b1, {tag, " valid"}, int'(ov), 1);
      chk(od == e[7:0], tag, int'(od), e);
      rdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0;
    end
    chk(ov == 1'b0, {tag, " empty"}, int'(ov), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ov == 1'b0, "reset out_valid", int'(ov), 0);

    // R3: nothing to report
    sync1(); drain("R3 quiet sync");

    // R2 R5 R7: small motion, y sign inverted
    move(5, 3); sync1(); drain("R2 small motion");
    move(-20, -9); move(7, 2); sync1(); drain("R2 mixed motion");

    // R5 R6: large motion carried over several reports
    move(300, -200);
    for (int k = 0; k < 4; k++) begin
      sync1(); drain("R6 carry");
    end

    // R1 R4: buttons, flag cleared after send
    drive(0, 0, 0, 3'b100, 3'b100, 0); sync1(); drain("R1 left press");
    sync1(); drain("R4 flag cleared");
    drive(0, 0, 0, 3'b011, 3'b011, 0); sync1(); drain("R1 mid right press");
    drive(0, 0, 0, 3'b111, 3'b000, 0); move(1, 1); sync1(); drain("R4 release all");

    // R4: button event in sync cycle keeps flag for next report
    drive(0, 0, 0, 3'b001, 3'b001, 0);
    drive(0, 0, 0, 3'b010, 3'b010, 1);
    drain("R4 event at sync");
    sync1(); drain("R4 event carried");
    drive(0, 0, 0, 3'b011, 3'b000, 0); sync1(); drain("R1 cleanup");

    // R9: saturation on both axes
    for (int k = 0; k < 20; k++) move(2047, 2047);
    for (int k = 0; k < 16; k++) move(-2047, -2047);
    sync1(); drain("R9 saturation");

    // R8: overflow drops the tail of the second report
    move(5, 0); sync1(); idle(6);
    move(6, 0); sync1(); drain("R8 overflow");

    // R10: sync while busy ignored; move in sync cycle goes to next report
    move(4, 4);
    drive(8, 0, 1, 3'b0, 3'b0, 1);
    drive(9, 0, 1, 3'b0, 3'b0, 1);
    sync1(); sync1();
    drain("R10 busy sync");
    sync1(); drain("R10 next report");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule